// File: doc/BRIEF.md
# Multi-Master Bus Crossbar with Round-Robin Arbitration

This block is a simplified on-chip bus crossbar. It joins five bus masters (core instruction fetch, core literal/debug data, core system bus and two DMA engines) to seven slave ports (flash interface, SRAM, two peripheral bridges, the AHB1 peripheral group, GPIO and ADC). Each master presents a request with an address, a write flag and write data, and holds them until it sees ready. The crossbar decodes the address to one slave port and checks the master's permission for that slave. It then arbitrates per slave port and forwards the winning request. Read data, ready and the slave's error flag come back to that master.

Every slave port has its own round-robin arbiter. Masters that aim at different slaves proceed in the same cycle. A granted master keeps its slave through any wait states until the slave signals ready. An access to an unmapped address, or to a slave the master may not use, never reaches a slave port. It gets a local two-cycle error response instead. The address windows and the permission matrix are parameters.

Top module: `mbus_xbar`

## Requirements
- R1: Slave port index follows the address: 0 flash 0x0800_0000–0x0807_FFFF, 1 SRAM 0x2000_0000–0x2000_FFFF, 2 low peripheral bridge 0x4000_0000–0x4000_FFFF, 3 high peripheral bridge 0x4001_0000–0x4001_FFFF, 4 AHB1 group 0x4002_0000–0x4002_7FFF, 5 GPIO 0x4800_0000–0x4800_1FFF, 6 ADC 0x5000_0000–0x5000_03FF.
- R2: Masters 0 (instruction) and 1 (literal/debug) may reach only slaves 0 and 1. Master 2 (system) may reach slaves 1 to 6 but not flash. Masters 3 and 4 (DMA) may reach all seven.
- R3: A request to an unmapped address or to a forbidden slave asserts no slave request. The master sees m_err=1 with m_ready=0 in the first cycle, then m_err=1 with m_ready=1 in the second.
- R4: The granted master's address, write flag, write data and index appear on the slave port. The slave's read data, ready and error flag are returned to that master.
- R5: A master's m_ready follows its slave's s_ready, so a slave with N wait states completes in N+1 cycles. The granted master keeps the slave unchanged until s_ready.
- R6: Each slave port grants the first requesting master found searching upward, with wrap-around, from its pointer. When a transfer completes, the pointer moves to the master after the one just served.
- R7: Masters targeting different slaves are granted and completed in the same cycle, and no master drives more than one slave port.
- R8: After reset, with no requests, every s_req, m_ready and m_err is 0 and all pointers start at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Per-master request, held until m_ready |
| m_addr | input | NM×AW | Per-master byte address |
| m_write | input | NM | Per-master write flag |
| m_wdata | input | NM×DW | Per-master write data |
| m_ready | output | NM | Transfer complete for that master |
| m_err | output | NM | Error response to that master |
| m_rdata | output | NM×DW | Read data to that master |
| s_req | output | NS | Request on each slave port |
| s_addr | output | NS×AW | Forwarded address per slave port |
| s_write | output | NS | Forwarded write flag per slave port |
| s_wdata | output | NS×DW | Forwarded write data per slave port |
| s_master | output | NS×MIW | Index of the granted master per slave port |
| s_ready | input | NS | Slave completes the current transfer |
| s_err | input | NS | Slave error flag, valid with s_ready |
| s_rdata | input | NS×DW | Slave read data |

## Verification
The bench builds the crossbar with its default parameters: five masters, seven slaves, 32-bit address and data, and the windows and permission matrix above. It drives all seven slave ports from a model with one wait state on flash and two on the low peripheral bridge. This makes multi-cycle ownership and the held-grant path observable. The ADC slave returns an error for addresses with bit 2 set, so slave error forwarding is exercised. Contention runs three masters on one slave port, which makes pointer wrap-around visible in the grant order.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   // width of a master index, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // slot reached by stepping 'off' places from 'base' in a ring of 'n'
   function automatic int rr_slot(input int base, input int off, input int n);
      return (base + off) % n;
   endfunction

endpackage

// File: rtl/xbar_mdec.sv
module xbar_mdec #(
   parameter int NS = 7,
   parameter int AW = 32,
   parameter logic [NS-1:0][AW-1:0] BASE = '0,
   parameter logic [NS-1:0][AW-1:0] MASK = '0,
   parameter logic [NS-1:0]         ALLOW = '1
) (
   input  logic [AW-1:0] addr,
   output logic [NS-1:0] tgt,
   output logic          legal
);

   logic [NS-1:0] hit;

   for (genvar s = 0; s < NS; s++) begin : g_win
      assign hit[s] = ((addr & MASK[s]) == BASE[s]);
   end

   assign tgt   = hit & ALLOW;
   assign legal = |tgt;

endmodule

// File: rtl/xbar_errresp.sv
module xbar_errresp (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic legal,
   output logic err,
   output logic rdy
);

   logic second_q;
   logic bad;

   assign bad = req & ~legal;

   always_comb begin
      if (second_q) begin
         err = 1'b1;
         rdy = 1'b1;
      end else begin
         err = bad;
         rdy = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        second_q <= 1'b0;
      else if (second_q) second_q <= 1'b0;
      else               second_q <= bad;
   end

endmodule

// File: rtl/xbar_rrarb.sv
module xbar_rrarb import xbar_pkg::*; #(
   parameter  int NM  = 5,
   localparam int MIW = idx_w(NM)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NM-1:0]  req,
   input  logic           done,
   output logic [NM-1:0]  gnt,
   output logic [MIW-1:0] gnt_idx,
   output logic           active
);

   logic           busy_q;
   logic [MIW-1:0] own_q;
   logic [MIW-1:0] ptr_q;
   logic [MIW-1:0] pick;
   logic           found;

   if (NM == 1) begin : g_single
      assign found = req[0];
      assign pick  = '0;
   end else begin : g_ring
      always_comb begin
         found = 1'b0;
         pick  = '0;
         for (int k = 0; k < NM; k++) begin
            if (!found && req[rr_slot(int'(ptr_q), k, NM)]) begin
               found = 1'b1;
               pick  = MIW'(rr_slot(int'(ptr_q), k, NM));
            end
         end
      end
   end

   assign gnt_idx = busy_q ? own_q : pick;
   assign active  = busy_q | found;

   for (genvar m = 0; m < NM; m++) begin : g_gnt
      assign gnt[m] = active && (gnt_idx == MIW'(m));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         own_q  <= '0;
         ptr_q  <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
         ptr_q  <= MIW'(rr_slot(int'(gnt_idx), 1, NM));
      end else if (active) begin
         busy_q <= 1'b1;
         own_q  <= gnt_idx;
      end
   end

endmodule

// File: rtl/mbus_xbar.sv
module mbus_xbar import xbar_pkg::*; #(
   parameter  int NM = 5,
   parameter  int NS = 7,
   parameter  int AW = 32,
   parameter  int DW = 32,
   parameter  logic [NS-1:0][AW-1:0] BASE = {
      32'h5000_0000, 32'h4800_0000, 32'h4002_0000, 32'h4001_0000,
      32'h4000_0000, 32'h2000_0000, 32'h0800_0000},
   parameter  logic [NS-1:0][AW-1:0] MASK = {
      32'hFFFF_FC00, 32'hFFFF_E000, 32'hFFFF_8000, 32'hFFFF_0000,
      32'hFFFF_0000, 32'hFFFF_0000, 32'hFFF8_0000},
   parameter  logic [NM-1:0][NS-1:0] PERMIT = {
      7'h7F, 7'h7F, 7'h7E, 7'h03, 7'h03},
   localparam int MIW = idx_w(NM)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NM-1:0]          m_req,
   input  logic [NM-1:0][AW-1:0]  m_addr,
   input  logic [NM-1:0]          m_write,
   input  logic [NM-1:0][DW-1:0]  m_wdata,
   output logic [NM-1:0]          m_ready,
   output logic [NM-1:0]          m_err,
   output logic [NM-1:0][DW-1:0]  m_rdata,
   output logic [NS-1:0]          s_req,
   output logic [NS-1:0][AW-1:0]  s_addr,
   output logic [NS-1:0]          s_write,
   output logic [NS-1:0][DW-1:0]  s_wdata,
   output logic [NS-1:0][MIW-1:0] s_master,
   input  logic [NS-1:0]          s_ready,
   input  logic [NS-1:0]          s_err,
   input  logic [NS-1:0][DW-1:0]  s_rdata
);

   // elaboration-time parameter checks
   if (NM < 1 || NS < 1) begin : g_bad_count
      $error("crossbar needs at least one master and one slave");
   end
   if (AW < 8 || DW < 8) begin : g_bad_width
      $error("address and data widths must be at least 8");
   end
   for (genvar s = 0; s < NS; s++) begin : g_chk_win
      if ((BASE[s] & ~MASK[s]) != '0) begin : g_misaligned
         $error("slave window base not aligned to its mask");
      end
   end

   logic [NM-1:0][NS-1:0] tgt;
   logic [NM-1:0]         legal;
   logic [NM-1:0]         e_err;
   logic [NM-1:0]         e_rdy;
   logic [NS-1:0][NM-1:0] req_sm;
   logic [NS-1:0][NM-1:0] gnt_sm;
   logic [NS-1:0]         act;

   // per-master decode and local error response
   for (genvar m = 0; m < NM; m++) begin : g_mst
      xbar_mdec #(
         .NS(NS), .AW(AW), .BASE(BASE), .MASK(MASK), .ALLOW(PERMIT[m])
      ) u_dec (
         .addr  (m_addr[m]),
         .tgt   (tgt[m]),
         .legal (legal[m])
      );

      xbar_errresp u_err (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (m_req[m]),
         .legal (legal[m]),
         .err   (e_err[m]),
         .rdy   (e_rdy[m])
      );
   end

   // per-slave arbitration
   for (genvar s = 0; s < NS; s++) begin : g_slv
      for (genvar m = 0; m < NM; m++) begin : g_req
         assign req_sm[s][m] = m_req[m] & tgt[m][s];
      end

      xbar_rrarb #(.NM(NM)) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req_sm[s]),
         .done    (s_ready[s] & act[s]),
         .gnt     (gnt_sm[s]),
         .gnt_idx (s_master[s]),
         .active  (act[s])
      );

      assign s_req[s] = act[s];
   end

   // forward path: AND-OR select of the granted master per slave
   always_comb begin
      s_addr  = '0;
      s_write = '0;
      s_wdata = '0;
      for (int s = 0; s < NS; s++) begin
         for (int m = 0; m < NM; m++) begin
            if (gnt_sm[s][m]) begin
               s_addr[s]  = s_addr[s]  | m_addr[m];
               s_write[s] = s_write[s] | m_write[m];
               s_wdata[s] = s_wdata[s] | m_wdata[m];
            end
         end
      end
   end

   // return path: the slave owned by each master, merged with local errors
   always_comb begin
      m_ready = e_rdy;
      m_err   = e_err;
      m_rdata = '0;
      for (int m = 0; m < NM; m++) begin
         for (int s = 0; s < NS; s++) begin
            if (gnt_sm[s][m]) begin
               m_ready[m] = m_ready[m] | s_ready[s];
               m_err[m]   = m_err[m]   | (s_err[s] & s_ready[s]);
               m_rdata[m] = m_rdata[m] | s_rdata[s];
            end
         end
      end
   end

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk import xbar_pkg::*; #(
   parameter  int NM = 5,
   parameter  int NS = 7,
   parameter  int AW = 32,
   parameter  int DW = 32,
   parameter  logic [NS-1:0][AW-1:0] BASE = '0,
   parameter  logic [NS-1:0][AW-1:0] MASK = '0,
   parameter  logic [NM-1:0][NS-1:0] PERMIT = '0,
   localparam int MIW = idx_w(NM)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NM-1:0]          m_req,
   input logic [NM-1:0]          m_ready,
   input logic [NM-1:0]          m_err,
   input logic [NS-1:0]          s_req,
   input logic [NS-1:0]          s_ready,
   input logic [NS-1:0][AW-1:0]  s_addr,
   input logic [NS-1:0][MIW-1:0] s_master
);

   logic [NM-1:0][NS-1:0] own;

   always_comb begin
      for (int m = 0; m < NM; m++)
         for (int s = 0; s < NS; s++)
            own[m][s] = s_req[s] && (s_master[s] == MIW'(m));
   end

   for (genvar m = 0; m < NM; m++) begin : g_m
      AST_ERR_SECOND_BEAT: assert property ( // R3
         @(posedge clk) disable iff (!rst_n)
         (m_err[m] && !m_ready[m]) |=> (m_err[m] && m_ready[m]));

      AST_ONE_TARGET_PER_MASTER: assert property ( // R7
         @(posedge clk) disable iff (!rst_n)
         $countones(own[m]) <= 1);
   end

   for (genvar s = 0; s < NS; s++) begin : g_s
      AST_ADDR_IN_WINDOW: assert property ( // R1
         @(posedge clk) disable iff (!rst_n)
         s_req[s] |-> ((s_addr[s] & MASK[s]) == BASE[s]));

      AST_OWNER_PERMITTED: assert property ( // R2
         @(posedge clk) disable iff (!rst_n)
         s_req[s] |-> PERMIT[s_master[s]][s]);

      AST_OWNER_REQUESTING: assert property ( // R4
         @(posedge clk) disable iff (!rst_n)
         s_req[s] |-> m_req[s_master[s]]);

      AST_GRANT_HELD: assert property ( // R5
         @(posedge clk) disable iff (!rst_n)
         (s_req[s] && !s_ready[s]) |=> (s_req[s] && $stable(s_master[s]) && $stable(s_addr[s])));
   end

endmodule

bind mbus_xbar xbar_chk #(
   .NM(NM), .NS(NS), .AW(AW), .DW(DW),
   .BASE(BASE), .MASK(MASK), .PERMIT(PERMIT)
) u_chk (.*);

// File: tb/tb_mbus_xbar.sv
`timescale 1ns/1ps
module tb_mbus_xbar;

   localparam int NM = 5;
   localparam int NS = 7;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int MIW = 3;
   localparam int WAITS [NS] = '{1, 0, 2, 0, 0, 0, 0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NM-1:0]          m_req = '0;
   logic [NM-1:0][AW-1:0]  m_addr = '0;
   logic [NM-1:0]          m_write = '0;
   logic [NM-1:0][DW-1:0]  m_wdata = '0;
   logic [NM-1:0]          m_ready;
   logic [NM-1:0]          m_err;
   logic [NM-1:0][DW-1:0]  m_rdata;
   logic [NS-1:0]          s_req;
   logic [NS-1:0][AW-1:0]  s_addr;
   logic [NS-1:0]          s_write;
   logic [NS-1:0][DW-1:0]  s_wdata;
   logic [NS-1:0][MIW-1:0] s_master;
   logic [NS-1:0]          s_ready;
   logic [NS-1:0]          s_err;
   logic [NS-1:0][DW-1:0]  s_rdata;

   mbus_xbar dut (.*);

   // slave models: fixed wait count, data = address plus slave index
   int wcnt [NS];
   always_ff @(posedge clk) begin
      for (int s = 0; s < NS; s++) begin
         if (!rst_n)        wcnt[s] <= 0;
         else if (s_req[s]) wcnt[s] <= s_ready[s] ? 0 : wcnt[s] + 1;
      end
   end
   always_comb begin
      for (int s = 0; s < NS; s++) begin
         s_ready[s] = s_req[s] && (wcnt[s] == WAITS[s]);
         s_rdata[s] = s_addr[s] + DW'(s);
         s_err[s]   = (s == 6) && s_addr[s][2];
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   typedef struct packed {
      logic [2:0]  m;
      logic [31:0] a;
      logic        we;
      logic [2:0]  slv;
      logic        xerr;
      logic [3:0]  cyc;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 32'h0800_0010, 1'b0, 3'd0, 1'b0, 4'd2},  // R1 flash, one wait
      '{3'd1, 32'h2000_0100, 1'b1, 3'd1, 1'b0, 4'd1},  // R4 write to SRAM
      '{3'd0, 32'h4000_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 fetch bus to bridge
      '{3'd2, 32'h0800_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 system bus to flash
      '{3'd2, 32'h4000_0400, 1'b0, 3'd2, 1'b0, 4'd3},  // R5 two waits
      '{3'd2, 32'h4001_3800, 1'b1, 3'd3, 1'b0, 4'd1},  // R1 high bridge
      '{3'd3, 32'h4002_1000, 1'b0, 3'd4, 1'b0, 4'd1},  // R1 AHB1 group
      '{3'd4, 32'h4800_0400, 1'b1, 3'd5, 1'b0, 4'd1},  // R1 GPIO
      '{3'd2, 32'h5000_0000, 1'b0, 3'd6, 1'b0, 4'd1},  // R1 ADC
      '{3'd3, 32'h3000_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R3 unmapped
      '{3'd4, 32'h0807_FFFC, 1'b0, 3'd0, 1'b0, 4'd2},  // R1 top of flash
      '{3'd4, 32'h0808_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R3 just past flash
      '{3'd1, 32'h2000_FFFC, 1'b0, 3'd1, 1'b0, 4'd1},  // R1 top of SRAM
      '{3'd2, 32'h2001_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R3 just past SRAM
      '{3'd2, 32'h5000_0004, 1'b0, 3'd6, 1'b1, 4'd1},  // R4 slave error
      '{3'd1, 32'h4800_0000, 1'b0, 3'd0, 1'b1, 4'd2}   // R2 data bus to GPIO
   };

   task automatic run_vec(input vec_t v);
      int m, cyc;
      bit touched;
      logic rdy_seen, err_got;
      logic [DW-1:0] rd;
      logic [AW-1:0] sa;
      logic sw;
      logic [DW-1:0] swd;
      logic [MIW-1:0] sm;
      logic sr;
      m = int'(v.m);
      @(negedge clk);
      m_req[m] = 1'b1;
      m_addr[m] = v.a;
      m_write[m] = v.we;
      m_wdata[m] = ~v.a;
      cyc = 0;
      touched = 0;
      rdy_seen = 0;
      forever begin
         #1;
         cyc++;
         if (s_req != '0) touched = 1;
         if (m_ready[m]) begin
            rdy_seen = 1;
            break;
         end
         if (cyc > 20) break;
         @(negedge clk);
      end
      err_got = m_err[m];
      rd  = m_rdata[m];
      sr  = s_req[v.slv];
      sa  = s_addr[v.slv];
      sw  = s_write[v.slv];
      swd = s_wdata[v.slv];
      sm  = s_master[v.slv];
      @(negedge clk);
      m_req[m] = 1'b0;
      chk(rdy_seen && cyc == int'(v.cyc), "R5 R3 completion cycle", cyc, v.cyc);
      chk(err_got == v.xerr, "R3 R4 error flag", err_got, v.xerr);
      if (v.xerr && v.cyc == 4'd2) begin
         chk(!touched, "R2 R3 no slave touched", touched, 0);
      end else begin
         chk(sr && sa == v.a && sm == v.m, "R1 R4 slave port address/owner", sa, v.a);
         chk(sw == v.we, "R4 write flag", sw, v.we);
         if (v.we) chk(swd == ~v.a, "R4 write data", swd, ~v.a);
         else      chk(rd == v.a + 32'(v.slv), "R4 read data", rd, v.a + 32'(v.slv));
      end
   endtask

   // three masters contend for one slave; record four grant owners
   task automatic rr_run(input int slv, input int ma, input int mb, input int mc,
                         input logic [31:0] base, input int per,
                         input int e0, input int e1, input int e2, input int e3);
      int got [4];
      int exp [4];
      int n, cyc, last;
      exp = '{e0, e1, e2, e3};
      got = '{-1, -1, -1, -1};
      @(negedge clk);
      m_req[ma] = 1'b1; m_addr[ma] = base + 32'(ma * 16); m_write[ma] = 1'b0;
      m_req[mb] = 1'b1; m_addr[mb] = base + 32'(mb * 16); m_write[mb] = 1'b0;
      m_req[mc] = 1'b1; m_addr[mc] = base + 32'(mc * 16); m_write[mc] = 1'b0;
      n = 0; cyc = 0; last = 0;
      while (n < 4 && cyc < 100) begin
         #1;
         cyc++;
         if (s_ready[slv]) begin
            got[n] = int'(s_master[slv]);
            chk(cyc - last == per, "R5 held ownership length", cyc - last, per);
            last = cyc;
            n++;
         end
         @(negedge clk);
      end
      m_req = '0;
      for (int i = 0; i < 4; i++)
         chk(got[i] == exp[i], "R6 round-robin order", got[i], exp[i]);
   endtask

   initial begin
      // R8 reset state
      repeat (3) @(posedge clk);
      #1;
      chk(s_req == '0 && m_ready == '0 && m_err == '0, "R8 outputs in reset", s_req, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(s_req == '0 && m_ready == '0 && m_err == '0, "R8 idle after reset", s_req, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R7 three masters on three slaves at once
      @(negedge clk);
      m_req[0] = 1'b1; m_addr[0] = 32'h0800_0040;
      m_req[1] = 1'b1; m_addr[1] = 32'h2000_0040;
      m_req[2] = 1'b1; m_addr[2] = 32'h5000_0040;
      #1;
      chk(s_req == 7'b100_0011, "R7 parallel slave requests", s_req, 7'b100_0011);
      chk(m_ready == 5'b00110, "R7 same-cycle completions", m_ready, 5'b00110);
      @(negedge clk);
      #1;
      chk(m_ready[0] == 1'b1, "R7 flash completes after wait", m_ready[0], 1);
      @(negedge clk);
      m_req = '0;

      // R6 on low bridge: pointer is 3 after vector 4 granted master 2
      rr_run(2, 2, 3, 4, 32'h4000_0000, 3, 3, 4, 2, 3);
      // R6 on SRAM: pointer is 2 after master 1; wraps past master 4 back to 1
      rr_run(1, 1, 3, 4, 32'h2000_0000, 1, 3, 4, 1, 3);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule